// File: doc/BRIEF.md
# Load/Store Issue Controller

This block sits between an instruction sequencer and the data cache and decides when each memory access may leave the core. It takes a load, a store or a synchronizing instruction from the sequencer once its operands are ready. For loads and stores it asks the integer unit for the effective address in the same cycle. It then either sends the access to the data cache at once or parks it in a small in-order address queue, with a store data queue that shares its pointers.

Loads stream into the cache and several may be outstanding at once. A store waits until everything older has terminated and no exception is being signalled, so interrupts stay precise. One idle clock always separates a load's termination from the issue of the store behind it. Synchronizing instructions enter only into an empty machine. The serializing kind also blocks any further intake until it has terminated. Update-form accesses write their base register back one clock after they are taken. An exception indication flushes every access that is still queued.

Top module: `lsic_top`

## Requirements
- R1: `seq_accept` is high exactly when `seq_valid` and `seq_ops_ready` are high, `older_exc` is low, no serializing instruction is pending, the address queue holds fewer than AQ_DEPTH entries, and (for synchronizing ops) R5's entry condition holds.
- R2: A load or store taken while the address queue is empty goes to the cache in the same cycle if its issue rule allows it; otherwise it is queued. `ea_req` is high in the take cycle of every load or store (op 0 or 1) and never for ops 2 and 3.
- R3: Cache requests leave in the order instructions were taken. A queued head that may issue is issued in that cycle.
- R4: A load or store taken with `seq_update` high gives, one clock later, `wb_valid` high with `wb_reg` equal to its `seq_base` and `wb_addr` equal to the `ea_value` seen at take. Otherwise `wb_valid` is low.
- R5: Op 2 (move, wait-before) and op 3 (serialize) are taken only when `older_done` is high, the address queue is empty and no cache access is outstanding. They issue in the take cycle with `dc_op` equal to their op.
- R6: After an op 3 is taken, `seq_accept` stays low up to and including the cycle of its `dc_done`.
- R7: A store (`dc_op`=1) is issued only when `older_done` is high, `older_exc` is low and no access is outstanding.
- R8: A store is never issued in the clock right after a `dc_done` that ended a load. When a store is otherwise ready, it issues exactly two clocks after that `dc_done`.
- R9: Loads issue back to back with up to OUT_DEPTH outstanding. A load that finds OUT_DEPTH outstanding waits until one terminates.
- R10: In a cycle with `older_exc` high, nothing is taken and nothing is issued, and every queued entry is discarded.
- R11: A queued store presents its own address and data in the same request beat.
- R12: After reset, with idle inputs, `seq_accept`, `dc_req` and `wb_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| seq_valid | input | 1 | Sequencer presents an instruction |
| seq_ops_ready | input | 1 | All operands of the presented instruction are available |
| seq_op | input | 2 | 0 load, 1 store, 2 move (wait-before), 3 serialize |
| seq_update | input | 1 | Update form: base register is written back |
| seq_base | input | REG_W | Base register number |
| seq_wdata | input | DATA_W | Store data |
| seq_accept | output | 1 | Instruction taken this cycle |
| ea_req | output | 1 | Effective-address request to the integer unit |
| ea_value | input | ADDR_W | Effective address returned in the same cycle |
| older_done | input | 1 | All older non-memory instructions have terminated |
| older_exc | input | 1 | An older instruction terminated with an exception |
| dc_req | output | 1 | Access request to the data cache |
| dc_op | output | 2 | Op of the request (encoding as seq_op) |
| dc_addr | output | ADDR_W | Request address |
| dc_wdata | output | DATA_W | Request store data |
| dc_done | input | 1 | Oldest outstanding access terminated |
| wb_valid | output | 1 | Base register writeback valid |
| wb_reg | output | REG_W | Writeback register number |
| wb_addr | output | ADDR_W | Writeback value (effective address) |

## Verification
The main function is tried with random mixes of loads, stores and synchronizing ops. These run under toggling termination, operand readiness, sparse exception pulses and random cache completions. Each cycle the accept and issue decisions are compared against rules derived from the requirements, which separates a missing issue from a wrongly gated one. Directed sequences isolate the cases the random mix seldom lines up: a store parked behind a blocked head, a full queue, a flush of queued stores, a load followed by a store (the one-clock gap), five back-to-back loads against a depth of four, and a serializing op holding off the next load.

// File: rtl/lsic_pkg.sv
package lsic_pkg;
    typedef enum logic [1:0] {
        OP_LOAD   = 2'd0,
        OP_STORE  = 2'd1,
        OP_MOVE   = 2'd2,
        OP_SERIAL = 2'd3
    } lsic_op_e;

    // synchronizing classes enter only into an empty machine
    function automatic logic is_sync(input lsic_op_e op);
        return op[1];
    endfunction
endpackage

// File: rtl/lsic_queue.sv
module lsic_queue #(
    parameter int W     = 32,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         flush,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [PW-1:0] wr;
        logic [PW-1:0] rd;
        logic [CW-1:0] cnt;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [W-1:0] mem_q [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        if (flush) begin
            ptr_d = '0;
        end else begin
            if (push) ptr_d.wr = bump(ptr_q.wr);
            if (pop)  ptr_d.rd = bump(ptr_q.rd);
            ptr_d.cnt = ptr_q.cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (push && !flush) mem_q[ptr_q.wr] <= din;
    end

    assign dout  = mem_q[ptr_q.rd];
    assign empty = (ptr_q.cnt == '0);
    assign full  = (ptr_q.cnt == CW'(DEPTH));

    p_no_overflow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    p_no_underflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/lsic_inflight.sv
module lsic_inflight
    import lsic_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       issue,
    input  logic [1:0] issue_op,
    input  logic       done,
    output logic       empty,
    output logic       full,
    output logic [1:0] head_op,
    output logic       load_bubble
);
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][1:0] kind;
        logic [CW-1:0]         cnt;
        logic                  bub;
    } trk_t;

    trk_t trk_d, trk_q;
    logic [DEPTH-1:0][1:0] slot_nx;
    logic [CW-1:0]         wpos;

    assign wpos = trk_q.cnt - CW'(done);

    // each slot shifts toward the head on termination and takes a new op at the tail
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic [1:0] shifted;
        if (i < DEPTH - 1) begin : g_mid
            assign shifted = done ? trk_q.kind[i+1] : trk_q.kind[i];
        end else begin : g_last
            assign shifted = done ? 2'd0 : trk_q.kind[i];
        end
        assign slot_nx[i] = (issue && wpos == CW'(i)) ? issue_op : shifted;
    end

    always_comb begin
        trk_d      = trk_q;
        trk_d.kind = slot_nx;
        trk_d.cnt  = trk_q.cnt + CW'(issue) - CW'(done);
        trk_d.bub  = done && (trk_q.cnt != '0) && (trk_q.kind[0] == OP_LOAD);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) trk_q <= '0;
        else        trk_q <= trk_d;
    end

    assign empty       = (trk_q.cnt == '0);
    assign full        = (trk_q.cnt == CW'(DEPTH));
    assign head_op     = trk_q.kind[0];
    assign load_bubble = trk_q.bub;

    p_done_owned_r3: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !empty);
    p_issue_room_r9: assert property (@(posedge clk) disable iff (!rst_n)
        issue |-> !full);
endmodule

// File: rtl/lsic_top.sv
module lsic_top
    import lsic_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int REG_W     = 5,
    parameter int AQ_DEPTH  = 4,
    parameter int OUT_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_valid,
    input  logic              seq_ops_ready,
    input  logic [1:0]        seq_op,
    input  logic              seq_update,
    input  logic [REG_W-1:0]  seq_base,
    input  logic [DATA_W-1:0] seq_wdata,
    output logic              seq_accept,
    output logic              ea_req,
    input  logic [ADDR_W-1:0] ea_value,
    input  logic              older_done,
    input  logic              older_exc,
    output logic              dc_req,
    output logic [1:0]        dc_op,
    output logic [ADDR_W-1:0] dc_addr,
    output logic [DATA_W-1:0] dc_wdata,
    input  logic              dc_done,
    output logic              wb_valid,
    output logic [REG_W-1:0]  wb_reg,
    output logic [ADDR_W-1:0] wb_addr
);
    localparam int AQ_W = ADDR_W + 2;

    typedef struct packed {
        logic              serial;
        logic              wb_v;
        logic [REG_W-1:0]  wb_r;
        logic [ADDR_W-1:0] wb_a;
    } st_t;

    st_t st_d, st_q;

    logic              aq_push, aq_pop, aq_empty, aq_full;
    logic [AQ_W-1:0]   aq_dout;
    logic              dq_empty, dq_full;
    logic [DATA_W-1:0] dq_dout;
    logic              if_empty, if_full, if_bubble;
    logic [1:0]        if_head;

    lsic_op_e          seq_kind, head_kind;
    logic              sync_ok, take, head_go, new_go;

    function automatic logic may_issue(input lsic_op_e k, input logic od,
                                       input logic exc, input logic emp,
                                       input logic ful, input logic bub);
        case (k)
            OP_LOAD:  return !ful;
            OP_STORE: return od && !exc && emp && !bub;
            default:  return 1'b1;
        endcase
    endfunction

    always_comb begin
        st_d      = st_q;
        seq_kind  = lsic_op_e'(seq_op);
        head_kind = lsic_op_e'(aq_dout[ADDR_W +: 2]);
        sync_ok   = older_done && aq_empty && if_empty;
        take      = seq_valid && seq_ops_ready && !older_exc && !st_q.serial
                    && !aq_full && !dq_full && (!is_sync(seq_kind) || sync_ok);
        head_go   = !aq_empty && !older_exc
                    && may_issue(head_kind, older_done, older_exc, if_empty, if_full, if_bubble);
        new_go    = aq_empty && take
                    && may_issue(seq_kind, older_done, older_exc, if_empty, if_full, if_bubble);
        aq_push   = take && !new_go;
        aq_pop    = head_go;

        seq_accept = take;
        ea_req     = take && !is_sync(seq_kind);
        dc_req     = head_go || new_go;
        dc_op      = head_go ? aq_dout[ADDR_W +: 2] : seq_op;
        dc_addr    = head_go ? aq_dout[ADDR_W-1:0] : ea_value;
        dc_wdata   = head_go ? dq_dout : seq_wdata;

        if (take && seq_kind == OP_SERIAL)
            st_d.serial = 1'b1;
        else if (dc_done && if_head == OP_SERIAL)
            st_d.serial = 1'b0;

        st_d.wb_v = take && !is_sync(seq_kind) && seq_update;
        st_d.wb_r = seq_base;
        st_d.wb_a = ea_value;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wb_valid = st_q.wb_v;
    assign wb_reg   = st_q.wb_r;
    assign wb_addr  = st_q.wb_a;

    lsic_queue #(.W(AQ_W), .DEPTH(AQ_DEPTH)) u_addr_q (
        .clk(clk), .rst_n(rst_n), .flush(older_exc),
        .push(aq_push), .din({seq_op, ea_value}), .pop(aq_pop),
        .dout(aq_dout), .empty(aq_empty), .full(aq_full)
    );

    lsic_queue #(.W(DATA_W), .DEPTH(AQ_DEPTH)) u_data_q (
        .clk(clk), .rst_n(rst_n), .flush(older_exc),
        .push(aq_push), .din(seq_wdata), .pop(aq_pop),
        .dout(dq_dout), .empty(dq_empty), .full(dq_full)
    );

    lsic_inflight #(.DEPTH(OUT_DEPTH)) u_inflight (
        .clk(clk), .rst_n(rst_n), .issue(dc_req), .issue_op(dc_op),
        .done(dc_done), .empty(if_empty), .full(if_full),
        .head_op(if_head), .load_bubble(if_bubble)
    );

    p_full_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
        aq_full |-> !seq_accept);
    p_same_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_accept && aq_empty && seq_op == 2'd0 && !if_full)
        |-> (dc_req && dc_addr == ea_value));
    p_wb_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_accept && !seq_op[1] && seq_update)
        |=> (wb_valid && wb_reg == $past(seq_base) && wb_addr == $past(ea_value)));
    p_sync_entry_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_accept && seq_op[1]) |-> (older_done && aq_empty && if_empty));
    p_serial_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.serial |-> !seq_accept);
    p_store_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_req && dc_op == 2'd1) |-> (older_done && !older_exc && if_empty));
    p_load_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_req && dc_op == 2'd1) |-> !if_bubble);
    p_flush_r10: assert property (@(posedge clk) disable iff (!rst_n)
        older_exc |=> aq_empty);
    p_lockstep_r11: assert property (@(posedge clk) disable iff (!rst_n)
        aq_empty == dq_empty);
endmodule

// File: tb/lsic_top_tb.sv
`timescale 1ns/1ps
module lsic_top_tb;
    localparam int AQ  = 4;
    localparam int OUT = 4;

    logic clk = 0;
    logic rst_n = 0;
    always #4 clk = ~clk;

    logic        v = 0, rdy = 0, upd = 0, od = 0, exc = 0, done = 0;
    logic [1:0]  op = 0;
    logic [4:0]  base = 0;
    logic [31:0] wd = 0, ea = 0;
    logic        seq_accept, ea_req, dc_req, wb_valid;
    logic [1:0]  dc_op;
    logic [31:0] dc_addr, dc_wdata, wb_addr;
    logic [4:0]  wb_reg;

    lsic_top u_dut (
        .clk(clk), .rst_n(rst_n), .seq_valid(v), .seq_ops_ready(rdy),
        .seq_op(op), .seq_update(upd), .seq_base(base), .seq_wdata(wd),
        .seq_accept(seq_accept), .ea_req(ea_req), .ea_value(ea),
        .older_done(od), .older_exc(exc), .dc_req(dc_req), .dc_op(dc_op),
        .dc_addr(dc_addr), .dc_wdata(dc_wdata), .dc_done(done),
        .wb_valid(wb_valid), .wb_reg(wb_reg), .wb_addr(wb_addr)
    );

    typedef struct {
        logic [1:0]  op;
        logic [31:0] a;
        logic [31:0] d;
    } ent_t;

    ent_t       pend[$];
    logic [1:0] infl[$];
    bit         serial_act = 0, bub = 0, ewb_v = 0, finished = 0;
    logic [4:0] ewb_r = 0;
    logic [31:0] ewb_a = 0;
    int nchk = 0, nfail = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    endtask

    // rule checks and scoreboard update, called just before each rising edge
    task automatic sample();
        bit sync_ok, exp_acc, exp_req, nbub;
        ent_t e;
        chk(wb_valid == ewb_v, "R4 wb_valid", wb_valid, ewb_v);
        if (ewb_v) chk(wb_reg == ewb_r && wb_addr == ewb_a, "R4 wb reg/addr",
                       {wb_reg, wb_addr}, {ewb_r, ewb_a});
        sync_ok = od && pend.size() == 0 && infl.size() == 0;
        exp_acc = v && rdy && !exc && !serial_act && pend.size() < AQ
                  && (!op[1] || sync_ok);
        chk(seq_accept == exp_acc, "R1/R5/R6 accept", seq_accept, exp_acc);
        chk(ea_req == (seq_accept && !op[1]), "R2 ea_req", ea_req, seq_accept && !op[1]);
        if (seq_accept) begin
            e.op = op; e.a = ea; e.d = wd;
            pend.push_back(e);
            if (op == 2'd3) serial_act = 1;
        end
        exp_req = 0;
        if (pend.size() > 0 && !exc) begin
            case (pend[0].op)
                2'd0:    exp_req = infl.size() < OUT;
                2'd1:    exp_req = od && infl.size() == 0 && !bub;
                default: exp_req = 1;
            endcase
        end
        chk(dc_req == exp_req, "R3/R7/R8/R9/R10 dc_req", dc_req, exp_req);
        if (dc_req && pend.size() > 0) begin
            chk(dc_op == pend[0].op && dc_addr == pend[0].a, "R3 order op/addr",
                {dc_op, dc_addr}, {pend[0].op, pend[0].a});
            if (dc_op == 2'd1)
                chk(dc_wdata == pend[0].d, "R11 store data", dc_wdata, pend[0].d);
            infl.push_back(pend[0].op);
            void'(pend.pop_front());
        end
        nbub = 0;
        if (done && infl.size() > 0) begin
            nbub = (infl[0] == 2'd0);
            if (infl[0] == 2'd3) serial_act = 0;
            void'(infl.pop_front());
        end
        bub = nbub;
        if (exc) pend.delete();
        ewb_v = seq_accept && !op[1] && upd;
        ewb_r = base;
        ewb_a = ea;
    endtask

    task automatic settle(); #3; endtask
    task automatic adv(); sample(); @(negedge clk); endtask
    task automatic idle(); v = 0; exc = 0; done = 0; upd = 0; endtask
    task automatic present(input logic [1:0] o, input logic [31:0] a,
                           input logic [31:0] d, input bit u);
        v = 1; rdy = 1; op = o; ea = a; wd = d; upd = u; base = a[4:0];
    endtask

    task automatic drain();
        for (int i = 0; i < 200; i++) begin
            if (pend.size() == 0 && infl.size() == 0) break;
            idle(); od = 1; done = infl.size() > 0;
            settle(); adv();
        end
        idle(); settle(); adv();
    endtask

    initial begin
        #(8 * 150000);
        chk(0, "watchdog expired", 0, 1);
        summary();
    end

    initial begin
        void'($urandom(32'h1d5e));
        repeat (3) @(negedge clk);
        settle();
        chk(!seq_accept && !dc_req && !wb_valid, "R12 reset outputs",
            {seq_accept, dc_req, wb_valid}, 0);
        @(negedge clk);
        rst_n = 1;
        idle(); settle();
        chk(!seq_accept && !dc_req && !wb_valid, "R12 idle after reset",
            {seq_accept, dc_req, wb_valid}, 0);
        adv();

        // R2 same-cycle issue, R4 writeback
        od = 1; present(2'd0, 32'h1000, 0, 1); settle();
        chk(seq_accept && dc_req && dc_addr == 32'h1000, "R2 load direct", dc_addr, 32'h1000);
        adv(); idle(); settle();
        chk(wb_valid && wb_addr == 32'h1000, "R4 update writeback", wb_addr, 32'h1000);
        adv(); drain();

        // R3 order / R11 data: store parks, load behind it
        od = 0; present(2'd1, 32'h2000, 32'hCAFE0001, 0); settle();
        chk(seq_accept && !dc_req, "R7 store held", dc_req, 0);
        adv(); present(2'd0, 32'h2004, 0, 0); settle();
        chk(seq_accept && !dc_req, "R3 load behind store", dc_req, 0);
        adv(); idle(); od = 1; settle();
        chk(dc_req && dc_op == 2'd1 && dc_wdata == 32'hCAFE0001, "R11 store beat",
            dc_wdata, 32'hCAFE0001);
        adv(); settle();
        chk(dc_req && dc_addr == 32'h2004, "R3 load second", dc_addr, 32'h2004);
        adv(); drain();

        // R1 full, R10 flush
        od = 0;
        for (int i = 0; i < AQ; i++) begin
            present(2'd1, 32'h3000 + i, i, 0); settle(); adv();
        end
        present(2'd1, 32'h3100, 0, 0); settle();
        chk(!seq_accept, "R1 full queue", seq_accept, 0);
        adv(); idle(); exc = 1; settle();
        chk(!seq_accept && !dc_req, "R10 exc cycle", {seq_accept, dc_req}, 0);
        adv(); exc = 0; od = 1;
        for (int i = 0; i < 3; i++) begin
            settle(); chk(!dc_req, "R10 flushed", dc_req, 0); adv();
        end

        // R8 one-clock gap after load termination
        od = 1; present(2'd0, 32'h4000, 0, 0); settle(); adv();
        present(2'd1, 32'h4004, 32'h55, 0); settle(); adv();
        idle(); done = 1; settle(); adv();
        done = 0; settle(); chk(!dc_req, "R8 gap clock", dc_req, 0); adv();
        settle(); chk(dc_req && dc_op == 2'd1, "R8 store after gap", dc_op, 1); adv();
        drain();

        // R9 pipelined loads
        od = 1;
        for (int i = 0; i < OUT; i++) begin
            present(2'd0, 32'h5000 + 4 * i, 0, 0); settle();
            chk(dc_req, "R9 back-to-back load", dc_req, 1); adv();
        end
        present(2'd0, 32'h5100, 0, 0); settle();
        chk(seq_accept && !dc_req, "R9 depth reached", dc_req, 0); adv();
        idle(); done = 1; settle(); adv();
        done = 0; settle(); chk(dc_req && dc_addr == 32'h5100, "R9 resumes", dc_addr, 32'h5100);
        adv(); drain();

        // R5 / R6 serialize
        od = 0; present(2'd3, 32'h6000, 0, 0); settle();
        chk(!seq_accept, "R5 waits for older", seq_accept, 0); adv();
        od = 1; settle();
        chk(seq_accept && dc_req && dc_op == 2'd3, "R5 serial issue", dc_op, 3); adv();
        present(2'd0, 32'h6004, 0, 0); settle();
        chk(!seq_accept, "R6 hold", seq_accept, 0); adv();
        done = 1; settle(); chk(!seq_accept, "R6 hold at done", seq_accept, 0); adv();
        done = 0; settle(); chk(seq_accept, "R6 released", seq_accept, 1); adv();
        idle(); drain();
        // move op: intake reopens the next cycle
        present(2'd2, 32'h7000, 0, 0); settle(); chk(seq_accept, "R5 move taken", seq_accept, 1); adv();
        present(2'd0, 32'h7004, 0, 0); settle(); chk(seq_accept, "R5 move no hold", seq_accept, 1); adv();
        drain();

        // constrained random
        for (int c = 0; c < 3000; c++) begin
            int r;
            r = $urandom_range(99);
            v = $urandom_range(99) < 70;
            rdy = $urandom_range(99) < 80;
            op = (r < 45) ? 2'd0 : (r < 85) ? 2'd1 : (r < 93) ? 2'd2 : 2'd3;
            upd = $urandom_range(99) < 30;
            base = 5'($urandom);
            ea = $urandom; wd = $urandom;
            od = $urandom_range(99) < 60;
            exc = $urandom_range(99) < 3;
            done = (infl.size() > 0) && ($urandom_range(99) < 50);
            settle(); adv();
        end
        drain();
        summary();
    end
endmodule